// File: doc/BRIEF.md
# Bit-Banged Serial Card Port Bridge

This block sits between a CPU's byte-wide I/O ports and a serial memory-card byte responder. Software produces the serial clock itself, either by toggling bits in a control register one write at a time or by writing a data port once per bit, in which case each write makes a complete clock pulse. The bridge samples the host data bit on the rising clock edge and rotates its receive and transmit bytes left on the falling edge, the usual mode-0 timing. It gathers eight bits into a byte and hands that byte to the responder, which answers with the next byte to shift back out.

The wiring scheme is a static input. In the toggle scheme, control register 0 carries power (bit 3), card select (bit 2, high selects), clock (bit 1) and host data (bit 0), and the card's returned bit is read on bit 7. In the pulse scheme, register 0 only keeps power and select. A write to register 1 makes one clock pulse that uses bit 7 of the written value, and a read of register 1 returns the whole transmit byte. While the card is deselected, sampled host bits go into the transmit register, so the bridge forwards the stream like a link in a ring. A byte that looks like a command, seen while the responder is idle, is delivered at once so that framing locks onto it.

Top module: `sdb_port_bridge`

## Requirements
- R1: After reset, reads of both registers return 0xFF in either scheme, and no byte is delivered.
- R2: In the toggle scheme, a read of either register returns bit 7 of the transmit register with bits 6..0 forced to 1.
- R3: With select high, the host bit is sampled into bit 0 of the receive byte on a rising edge, the receive byte rotates left on a falling edge, and at the falling edge that ends 8 rising edges the byte is delivered (first bit sent in bit 7) and the bit count returns to zero.
- R4: In the cycle a byte is delivered, the transmit register loads the responder byte. Each falling edge rotates it left, so bit 7 presents the responder byte MSB first.
- R5: While the responder reports idle and select is high, a sample that leaves bits 7..6 of the receive byte at 01 delivers that byte at once and clears the bit count, so the following byte is framed from that point.
- R6: With select low, the sampled host bit enters bit 0 of the transmit register instead of the receive byte, and no byte is delivered.
- R7: A write that changes the power bit sets the receive and transmit registers to 0xFF, clears the bit count and pulses the responder reset for one cycle. The clock bit of that same write is not taken as an edge.
- R8: With power off, clock edges and pulse writes change nothing.
- R9: In the pulse scheme, a write to register 1 with power on makes one rising and one falling edge, with the data taken from bit 7. The clock bit written to register 0 has no effect, and reads of register 0 return 0xFF.
- R10: In the pulse scheme, a read of register 1 returns the transmit register as it stood after the last rotate, before any responder load in that same pulse.
- R11: In the toggle scheme, register 1 is an alias of register 0 for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scheme_i | input | 1 | Static wiring scheme: 0 toggle, 1 pulse |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 1 | Write register select (0 control, 1 data) |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 1 | Read register select |
| rd_data_o | output | DW | Read data |
| rsp_idle_i | input | 1 | Responder is waiting for a command |
| rsp_tx_i | input | DW | Responder's next byte, taken on delivery |
| rsp_valid_o | output | 1 | A received byte is delivered this cycle |
| rsp_byte_o | output | DW | Delivered byte |
| rsp_reset_o | output | 1 | Responder return-to-power-up pulse |

## Verification
The hardest case to reach is the command realignment. The detector has to fire in the middle of a frame, on a bit count other than eight, after an ordinary misaligned byte has already been delivered. The stimulus gets there by sending a few filler ones and then the command byte, so the normal eight-edge delivery happens first and the 01 pattern completes three edges later. A further byte with the responder busy then shows that framing restarted at the command. Another hard case is the power-cycle flush in the middle of a byte. It is shown by a full byte that arrives cleanly after the three stale bits were discarded.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic {
    SCH_TOGGLE = 1'b0,
    SCH_PULSE  = 1'b1
  } scheme_e;

  localparam int unsigned PWR_BIT  = 3;
  localparam int unsigned SEL_BIT  = 2;
  localparam int unsigned CLK_BIT  = 1;
  localparam int unsigned DOUT_BIT = 0;

  typedef struct packed {
    logic pwr_chg;
    logic rise;
    logic fall;
    logic pulse;
    logic bit_v;
    logic sel;
  } edge_ev_t;
endpackage

// File: rtl/sdb_rst_sync.sv
module sdb_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sdb_host_decode.sv
module sdb_host_decode
  import sdb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  scheme_e       scheme_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output edge_ev_t      ev_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          wr_ctrl, pwr_chg, tog_ok;

  // In the toggle scheme both addresses reach the control register.
  assign wr_ctrl = wr_en_i && ((scheme_i == SCH_TOGGLE) || !wr_addr_i);
  assign pwr_chg = wr_ctrl && (wr_data_i[PWR_BIT] != ctrl_q[PWR_BIT]);
  assign tog_ok  = (scheme_i == SCH_TOGGLE) && wr_ctrl && !pwr_chg && wr_data_i[PWR_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wr_data_i;
  end

  always_comb begin
    ev_o.pwr_chg = pwr_chg;
    ev_o.rise    = tog_ok && !ctrl_q[CLK_BIT] && wr_data_i[CLK_BIT];
    ev_o.fall    = tog_ok && ctrl_q[CLK_BIT] && !wr_data_i[CLK_BIT];
    ev_o.pulse   = (scheme_i == SCH_PULSE) && wr_en_i && wr_addr_i && ctrl_q[PWR_BIT];
    ev_o.bit_v   = (scheme_i == SCH_PULSE) ? wr_data_i[DW-1] : wr_data_i[DOUT_BIT];
    ev_o.sel     = (scheme_i == SCH_PULSE) ? ctrl_q[SEL_BIT] : wr_data_i[SEL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  AST_OFF_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[PWR_BIT] && !pwr_chg) |-> !(ev_o.rise || ev_o.fall || ev_o.pulse)); // R8
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_o.pwr_chg, ev_o.rise, ev_o.fall, ev_o.pulse}) <= 1); // R7
endmodule

// File: rtl/sdb_shift_core.sv
module sdb_shift_core
  import sdb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  edge_ev_t      ev_i,
  input  logic          rsp_idle_i,
  input  logic [DW-1:0] rsp_tx_i,
  output logic [DW-1:0] tx_o,
  output logic [DW-1:0] snap_o,
  output logic          dlv_o,
  output logic [DW-1:0] dlv_byte_o
);
  localparam int unsigned CW = $clog2(DW) + 1;
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d, snap_q, snap_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, cnt_p;
  logic [DW-1:0] rx_s, tx_s, rx_p, tx_p, tx_r;
  logic          cmd_hit;

  assign rx_s    = {rx_q[DW-1:1], ev_i.bit_v};
  assign tx_s    = {tx_q[DW-1:1], ev_i.bit_v};
  assign cnt_inc = cnt_q + 1'b1;
  assign cmd_hit = ev_i.sel && rsp_idle_i && (rx_s[DW-1:DW-2] == 2'b01);
  assign rx_p    = ev_i.sel ? rx_s : rx_q;
  assign tx_p    = ev_i.sel ? tx_q : tx_s;
  assign tx_r    = {tx_p[DW-2:0], tx_p[DW-1]};
  assign cnt_p   = cmd_hit ? FULL : cnt_inc;

  always_comb begin
    rx_d       = rx_q;
    tx_d       = tx_q;
    snap_d     = snap_q;
    cnt_d      = cnt_q;
    dlv_o      = 1'b0;
    dlv_byte_o = rx_q;
    if (ev_i.pwr_chg) begin
      rx_d   = '1;
      tx_d   = '1;
      snap_d = '1;
      cnt_d  = '0;
    end else if (ev_i.rise) begin
      cnt_d = cnt_inc;
      if (ev_i.sel) begin
        rx_d = rx_s;
        if (cmd_hit) begin
          dlv_o      = 1'b1;
          dlv_byte_o = rx_s;
          cnt_d      = '0;
          tx_d       = rsp_tx_i;
        end
      end else begin
        tx_d = tx_s;
      end
    end else if (ev_i.fall) begin
      rx_d = {rx_q[DW-2:0], rx_q[DW-1]};
      tx_d = {tx_q[DW-2:0], tx_q[DW-1]};
      if (cnt_q == FULL) begin
        cnt_d = '0;
        if (ev_i.sel) begin
          dlv_o = 1'b1;
          tx_d  = rsp_tx_i;
        end
      end
    end else if (ev_i.pulse) begin
      rx_d   = {rx_p[DW-2:0], rx_p[DW-1]};
      snap_d = tx_r;
      tx_d   = tx_r;
      cnt_d  = cnt_p;
      if (cnt_p == FULL) begin
        cnt_d = '0;
        if (ev_i.sel) begin
          dlv_o      = 1'b1;
          dlv_byte_o = rx_p;
          tx_d       = rsp_tx_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '1;
      tx_q   <= '1;
      snap_q <= '1;
      cnt_q  <= '0;
    end else begin
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      snap_q <= snap_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tx_o   = tx_q;
  assign snap_o = snap_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R3
  AST_DLV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_o |=> (cnt_q == '0)); // R3
  AST_DLV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_o |=> (tx_q == $past(rsp_tx_i))); // R4
  AST_DLV_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_o |-> ev_i.sel); // R6
  AST_PWR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.pwr_chg |=> (cnt_q == '0 && rx_q == '1 && tx_q == '1)); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_i.pwr_chg || ev_i.rise || ev_i.fall || ev_i.pulse)
      |=> ($stable(rx_q) && $stable(cnt_q) && $stable(tx_q))); // R8
endmodule

// File: rtl/sdb_port_bridge.sv
module sdb_port_bridge
  import sdb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scheme_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          rsp_idle_i,
  input  logic [DW-1:0] rsp_tx_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_byte_o,
  output logic          rsp_reset_o
);
  localparam logic [DW-1:0] LOW_ONES = {1'b0, {(DW-1){1'b1}}};

  logic          rst_sync_n;
  scheme_e       scheme;
  edge_ev_t      ev;
  logic [DW-1:0] tx_val, snap_val;

  assign scheme = scheme_e'(scheme_i);

  sdb_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  sdb_host_decode #(.DW(DW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scheme_i  (scheme),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ev_o      (ev)
  );

  sdb_shift_core #(.DW(DW)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_i       (ev),
    .rsp_idle_i (rsp_idle_i),
    .rsp_tx_i   (rsp_tx_i),
    .tx_o       (tx_val),
    .snap_o     (snap_val),
    .dlv_o      (rsp_valid_o),
    .dlv_byte_o (rsp_byte_o)
  );

  assign rsp_reset_o = ev.pwr_chg;

  always_comb begin
    if (scheme == SCH_TOGGLE) rd_data_o = tx_val | LOW_ONES;
    else if (rd_addr_i)       rd_data_o = snap_val;
    else                      rd_data_o = '1;
  end

  AST_VALID_STABLE_PWR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_reset_o |-> !rsp_valid_o); // R7
endmodule

// File: tb/sdb_port_bridge_tb.sv
module sdb_port_bridge_tb;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scheme = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_addr = 1'b0;
  logic [DW-1:0] rd_data;
  logic rsp_idle = 1'b0;
  logic [DW-1:0] rsp_tx = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_byte;
  logic rsp_reset;

  int errors = 0;
  int checks = 0;
  int dlv_cnt = 0;
  int rstp_cnt = 0;
  logic [DW-1:0] last_byte = '0;

  always #(CLK_P/2) clk = ~clk;

  sdb_port_bridge #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scheme_i(scheme),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rsp_idle_i(rsp_idle), .rsp_tx_i(rsp_tx),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte), .rsp_reset_o(rsp_reset)
  );

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rsp_valid) begin
      dlv_cnt++;
      last_byte = rsp_byte;
    end
    if (rsp_reset) rstp_cnt++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sch);
    @(negedge clk);
    rst_n = 1'b0;
    scheme = sch;
    wr_en = 1'b0;
    rsp_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    dlv_cnt = 0;
    rstp_cnt = 0;
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic s0_bit(input logic a, input logic [DW-1:0] base, input logic b);
    wr(a, base | {7'b0, b});
    wr(a, base | 8'h02 | {7'b0, b});
    wr(a, base | {7'b0, b});
  endtask

  task automatic s0_byte(input logic a, input logic [DW-1:0] base, input logic [DW-1:0] v);
    for (int i = DW-1; i >= 0; i--) s0_bit(a, base, v[i]);
  endtask

  task automatic s1_byte(input logic [DW-1:0] v);
    for (int i = DW-1; i >= 0; i--) wr(1'b1, {v[i], 7'b0});
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    do_reset(1'b0);
    rd(1'b0, v); check("R1 toggle read after reset", v, 8'hFF);
    check("R1 no delivery after reset", dlv_cnt, 0);
    do_reset(1'b1);
    rd(1'b0, v); check("R1 pulse reg0 after reset", v, 8'hFF);
    rd(1'b1, v); check("R1 pulse reg1 after reset", v, 8'hFF);
  endtask

  task automatic t_s0_byte();
    logic [DW-1:0] v, got;
    do_reset(1'b0);
    wr(1'b0, 8'h08);
    check("R7 reset pulse on power up", rstp_cnt, 1);
    wr(1'b0, 8'h0C);
    rsp_tx = 8'hA5;
    s0_byte(1'b0, 8'h0C, 8'h3A);
    check("R3 one delivery", dlv_cnt, 1);
    check("R3 byte value", last_byte, 8'h3A);
    rd(1'b0, v); check("R2 read format bit7 high", v, 8'hFF);
    got = '0;
    for (int i = DW-1; i >= 0; i--) begin
      rd(1'b0, v);
      got[i] = v[7];
      check("R2 low bits forced", {1'b0, v[6:0]}, 8'h7F);
      s0_bit(1'b0, 8'h0C, 1'b0);
    end
    check("R4 responder byte shifted out MSB first", got, 8'hA5);
    check("R3 second byte", last_byte, 8'h00);
  endtask

  task automatic t_s0_cmd();
    logic [DW-1:0] v;
    logic [10:0] strm;
    do_reset(1'b0);
    wr(1'b0, 8'h0C);
    rsp_idle = 1'b1; rsp_tx = 8'hA5;
    strm = {3'b111, 8'h51};
    for (int i = 10; i >= 1; i--) s0_bit(1'b0, 8'h0C, strm[i]);
    check("R3 misaligned byte before command", last_byte, 8'hEA);
    wr(1'b0, 8'h0D);
    wr(1'b0, 8'h0F);
    check("R5 command delivered on rise", dlv_cnt, 2);
    check("R5 command byte", last_byte, 8'h51);
    rd(1'b0, v); check("R4 load on command rise", v, 8'hFF);
    rsp_idle = 1'b0;
    wr(1'b0, 8'h0D);
    rd(1'b0, v); check("R4 rotate after fall", v, 8'h7F);
    s0_byte(1'b0, 8'h0C, 8'h12);
    check("R5 realigned byte count", dlv_cnt, 3);
    check("R5 realigned byte", last_byte, 8'h12);
  endtask

  task automatic t_s0_ring();
    logic [DW-1:0] v;
    do_reset(1'b0);
    wr(1'b0, 8'h08);
    s0_byte(1'b0, 8'h08, 8'h3C);
    check("R6 no delivery when deselected", dlv_cnt, 0);
    rd(1'b0, v); check("R6 ring data in transmit", v, 8'h7F);
    s0_bit(1'b0, 8'h08, 1'b1);
    rd(1'b0, v); check("R6 ring next bit", v, 8'hFF);
  endtask

  task automatic t_s0_power();
    logic [DW-1:0] v;
    do_reset(1'b0);
    wr(1'b0, 8'h0C);
    rsp_tx = 8'h00;
    s0_bit(1'b0, 8'h0C, 1'b1);
    s0_bit(1'b0, 8'h0C, 1'b0);
    s0_bit(1'b0, 8'h0C, 1'b1);
    wr(1'b0, 8'h04);
    check("R7 reset pulse on power down", rstp_cnt, 2);
    rd(1'b0, v); check("R7 transmit flushed", v, 8'hFF);
    s0_byte(1'b0, 8'h04, 8'h00);
    check("R8 no delivery unpowered", dlv_cnt, 0);
    rd(1'b0, v); check("R8 transmit unchanged unpowered", v, 8'hFF);
    wr(1'b0, 8'h0C);
    check("R7 reset pulse on power up again", rstp_cnt, 3);
    s0_byte(1'b0, 8'h0C, 8'h6B);
    check("R7 count cleared: single delivery", dlv_cnt, 1);
    check("R7 count cleared: byte", last_byte, 8'h6B);
  endtask

  task automatic t_s0_alias();
    logic [DW-1:0] v, w;
    do_reset(1'b0);
    wr(1'b1, 8'h0C);
    check("R11 power via alias", rstp_cnt, 1);
    rsp_tx = 8'h33;
    s0_byte(1'b1, 8'h0C, 8'h81);
    check("R11 byte via alias", last_byte, 8'h81);
    rd(1'b1, v); check("R11 alias read", v, 8'h7F);
    rd(1'b0, w); check("R11 alias equals reg0", v, w);
  endtask

  task automatic t_s1_byte();
    logic [DW-1:0] v;
    do_reset(1'b1);
    wr(1'b0, 8'h0C);
    rsp_tx = 8'h5A;
    s1_byte(8'hC3);
    check("R9 pulse byte count", dlv_cnt, 1);
    check("R9 pulse byte value", last_byte, 8'hC3);
    rd(1'b1, v); check("R10 snapshot before load", v, 8'hFF);
    rd(1'b0, v); check("R9 reg0 reads ones", v, 8'hFF);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R10 snapshot after one pulse", v, 8'hB4);
    wr(1'b0, 8'h0E); wr(1'b0, 8'h0C); wr(1'b0, 8'h0E); wr(1'b0, 8'h0C);
    for (int i = 0; i < 7; i++) wr(1'b1, 8'h80);
    check("R9 reg0 clock bit ignored: count", dlv_cnt, 2);
    check("R9 reg0 clock bit ignored: byte", last_byte, 8'h7F);
  endtask

  task automatic t_s1_cmd();
    do_reset(1'b1);
    wr(1'b0, 8'h0C);
    rsp_idle = 1'b1;
    wr(1'b1, 8'h80); wr(1'b1, 8'h80);
    s1_byte(8'h40);
    check("R5 pulse scheme misaligned then command", dlv_cnt, 2);
    check("R5 pulse scheme command byte", last_byte, 8'h40);
    rsp_idle = 1'b0;
    s1_byte(8'h99);
    check("R5 pulse scheme realigned", last_byte, 8'h99);
  endtask

  task automatic t_s1_ring();
    logic [DW-1:0] v;
    do_reset(1'b1);
    wr(1'b0, 8'h08);
    s1_byte(8'h3C);
    check("R6 pulse ring no delivery", dlv_cnt, 0);
    rd(1'b1, v); check("R6 pulse ring transmit", v, 8'h78);
    wr(1'b0, 8'h00);
    rd(1'b1, v); check("R7 pulse power down flush", v, 8'hFF);
    for (int i = 0; i < 3; i++) wr(1'b1, 8'h00);
    rd(1'b1, v); check("R8 pulses ignored unpowered", v, 8'hFF);
    check("R8 no delivery unpowered pulse", dlv_cnt, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_s0_byte();
    t_s0_cmd();
    t_s0_ring();
    t_s0_power();
    t_s0_alias();
    t_s1_byte();
    t_s1_cmd();
    t_s1_ring();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule